// File: doc/BRIEF.md
# Channelized DMA Command-Port Programmer

This block is the programming front end of a multi-channel DMA controller. Software reaches it through two byte-wide write strobes that share one data bus: a command strobe and an execute strobe. A command byte carries an operation code in bits 7:4 and a channel number in bits 3:0. The execute bytes that follow are steered into one register of that channel: the I/O port, the address, the count or the mode. An internal byte pointer steers them, least significant byte first.

Each channel keeps its own mask bit. The block presents every channel's I/O port, start address, count, mode and a combined enable to the transfer engine that sits downstream. Two read operations return a channel's address or count one byte at a time through a read strobe. The normal programming order is: mask, mode, address, count, unmask.

Top module: `dma_cmd_prog`

## Requirements
- R1: After reset every channel is masked, its I/O port, address, count and mode read zero, every enable is low and `rdata` is 0. Execute bytes that arrive before the first command byte have no effect.
- R2: A command byte is decoded as opcode = bits 7:4 and channel = bits 3:0. A command byte on its own changes no I/O port, address, count or mode register. These registers change only on an accepted execute write.
- R3: Opcode 0x2 loads the channel's 24-bit address from three execute bytes, taken in the order bits 7:0, then 15:8, then 23:16.
- R4: Opcode 0x4 loads the channel's 16-bit count from two execute bytes, low byte first. The value is stored exactly as written. Software writes the transfer length minus one, counted in 16-bit words when mode bit 6 is set, so 0x7FFF with bit 6 set describes a 65536-byte transfer.
- R5: Opcode 0x0 loads the channel's 16-bit I/O port from two execute bytes, low byte first.
- R6: Opcode 0x7 stores one execute byte as the channel's mode. Bit 2 means transfer, bit 3 means read (clear means write), bit 0 means I/O-port mode, and bit 6 means 16-bit units.
- R7: Opcode 0x9 masks the selected channel and opcode 0xA unmasks it. A channel's enable is high exactly when the channel is unmasked and its mode bit 2 is set.
- R8: Every command byte resets the byte pointer to the first byte. Execute bytes beyond the number the opcode expects are ignored.
- R9: Opcodes other than 0x0, 0x2, 0x3, 0x4, 0x5, 0x7, 0x9 and 0xA are accepted, but they and the execute bytes that follow them change nothing.
- R10: Under opcode 0x3, each read strobe returns the next address byte on `rdata` one cycle later, low byte first. Opcode 0x5 does the same for the count. A read past the last byte, or a read under any other opcode, returns 0.
- R11: When a command strobe and an execute strobe fall in the same cycle, the command takes effect and the execute byte is ignored.
- R12: Programming one channel leaves the registers and enable of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command byte strobe |
| exec_we | input | 1 | Execute byte write strobe |
| exec_re | input | 1 | Execute byte read strobe |
| wdata | input | 8 | Byte shared by both write strobes |
| rdata | output | 8 | Registered readback byte |
| ch_ioport | output | NUM_CH*16 | I/O port of each channel, channel 0 in the low bits |
| ch_addr | output | NUM_CH*24 | Start address of each channel |
| ch_count | output | NUM_CH*16 | Count (length minus one) of each channel |
| ch_mode | output | NUM_CH*8 | Mode byte of each channel |
| ch_en | output | NUM_CH | Channel enable: unmasked and transfer bit set |

## Verification
The bench programs a full mask-mode-address-count-unmask sequence on one channel, then reads the address and count back, including one read past the end. The read-past-the-end case shows whether the byte pointer stops where it should. Surplus execute bytes and a repeated command show whether the pointer bounds and restarts correctly. Unlisted opcodes followed by execute bytes show that nothing is written by mistake. A mode written without the transfer bit, and a later mask, separate the two inputs of the enable. A command and an execute strobe in the same cycle show which one wins. The untouched channels are checked after each sequence, which exposes a wrong channel select.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam logic [3:0] OP_SET_IO   = 4'h0;
  localparam logic [3:0] OP_SET_ADDR = 4'h2;
  localparam logic [3:0] OP_GET_ADDR = 4'h3;
  localparam logic [3:0] OP_SET_CNT  = 4'h4;
  localparam logic [3:0] OP_GET_CNT  = 4'h5;
  localparam logic [3:0] OP_SET_MODE = 4'h7;
  localparam logic [3:0] OP_MASK     = 4'h9;
  localparam logic [3:0] OP_UNMASK   = 4'hA;
  localparam logic [3:0] OP_IDLE     = 4'hF;
  localparam int MODE_W        = 8;
  localparam int MODE_XFER_BIT = 2;
endpackage

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
  import dma_cmd_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int PTR_W  = 2,
  parameter int IO_B   = 2,
  parameter int ADDR_B = 3,
  parameter int CNT_B  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic             exec_we,
  input  logic             exec_re,
  input  logic [7:0]       wdata,
  output logic [3:0]       op_q,
  output logic [CH_W-1:0]  ch_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic             wr_io,
  output logic             wr_addr,
  output logic             wr_cnt,
  output logic             wr_mode,
  output logic             rd_go,
  output logic             mask_set,
  output logic             mask_clr
);
  logic [PTR_W-1:0] len;
  logic is_load, is_read, in_rng, wr_ok;

  always_comb begin
    case (op_q)
      OP_SET_IO:               len = PTR_W'(IO_B);
      OP_SET_ADDR, OP_GET_ADDR: len = PTR_W'(ADDR_B);
      OP_SET_CNT, OP_GET_CNT:  len = PTR_W'(CNT_B);
      OP_SET_MODE:             len = PTR_W'(1);
      default:                 len = '0;
    endcase
  end

  assign is_load = (op_q == OP_SET_IO) || (op_q == OP_SET_ADDR) ||
                   (op_q == OP_SET_CNT) || (op_q == OP_SET_MODE);
  assign is_read = (op_q == OP_GET_ADDR) || (op_q == OP_GET_CNT);
  assign in_rng  = (ptr_q < len);
  assign wr_ok   = exec_we && !cmd_we && in_rng;

  assign wr_io    = wr_ok && (op_q == OP_SET_IO);
  assign wr_addr  = wr_ok && (op_q == OP_SET_ADDR);
  assign wr_cnt   = wr_ok && (op_q == OP_SET_CNT);
  assign wr_mode  = wr_ok && (op_q == OP_SET_MODE);
  assign rd_go    = exec_re && !cmd_we;
  assign mask_set = cmd_we && (wdata[7:4] == OP_MASK);
  assign mask_clr = cmd_we && (wdata[7:4] == OP_UNMASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_IDLE;
      ch_q  <= '0;
      ptr_q <= '0;
    end else if (cmd_we) begin
      op_q  <= wdata[7:4];
      ch_q  <= wdata[CH_W-1:0];
      ptr_q <= '0;
    end else if (in_rng && ((exec_we && is_load) || (exec_re && is_read))) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_cmd_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int PTR_W  = 2,
  parameter int IO_W   = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CH_W-1:0]          sel_ch,
  input  logic [CH_W-1:0]          mask_ch,
  input  logic [PTR_W-1:0]         byte_idx,
  input  logic [7:0]               wbyte,
  input  logic                     wr_io,
  input  logic                     wr_addr,
  input  logic                     wr_cnt,
  input  logic                     wr_mode,
  input  logic                     mask_set,
  input  logic                     mask_clr,
  output logic [NUM_CH*IO_W-1:0]   ch_ioport,
  output logic [NUM_CH*ADDR_W-1:0] ch_addr,
  output logic [NUM_CH*CNT_W-1:0]  ch_count,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  output logic [NUM_CH-1:0]        ch_en
);
  localparam int IO_B   = IO_W / 8;
  localparam int ADDR_B = ADDR_W / 8;
  localparam int CNT_B  = CNT_W / 8;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic              hit, mhit;
    logic [IO_W-1:0]   io_r;
    logic [ADDR_W-1:0] addr_r;
    logic [CNT_W-1:0]  cnt_r;
    logic [MODE_W-1:0] mode_r;
    logic              mask_r;

    assign hit  = (sel_ch == CH_W'(g));
    assign mhit = (mask_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        io_r   <= '0;
        addr_r <= '0;
        cnt_r  <= '0;
        mode_r <= '0;
        mask_r <= 1'b1;
      end else begin
        for (int b = 0; b < IO_B; b++)
          if (wr_io && hit && byte_idx == PTR_W'(b)) io_r[b*8 +: 8] <= wbyte;
        for (int b = 0; b < ADDR_B; b++)
          if (wr_addr && hit && byte_idx == PTR_W'(b)) addr_r[b*8 +: 8] <= wbyte;
        for (int b = 0; b < CNT_B; b++)
          if (wr_cnt && hit && byte_idx == PTR_W'(b)) cnt_r[b*8 +: 8] <= wbyte;
        if (wr_mode && hit) mode_r <= wbyte;
        if (mask_set && mhit) mask_r <= 1'b1;
        else if (mask_clr && mhit) mask_r <= 1'b0;
      end
    end

    assign ch_ioport[g*IO_W +: IO_W]       = io_r;
    assign ch_addr[g*ADDR_W +: ADDR_W]     = addr_r;
    assign ch_count[g*CNT_W +: CNT_W]      = cnt_r;
    assign ch_mode[g*MODE_W +: MODE_W]     = mode_r;
    assign ch_en[g] = !mask_r && mode_r[MODE_XFER_BIT];
  end
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
  import dma_cmd_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int PTR_W  = 2,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_go,
  input  logic [3:0]               op,
  input  logic [CH_W-1:0]          ch,
  input  logic [PTR_W-1:0]         ptr,
  input  logic [NUM_CH*ADDR_W-1:0] addr_all,
  input  logic [NUM_CH*CNT_W-1:0]  cnt_all,
  output logic [7:0]               rdata
);
  localparam int ADDR_B = ADDR_W / 8;
  localparam int CNT_B  = CNT_W / 8;

  logic [ADDR_W-1:0] a_sel;
  logic [CNT_W-1:0]  c_sel;
  logic [7:0]        nxt;

  assign a_sel = addr_all[ch*ADDR_W +: ADDR_W];
  assign c_sel = cnt_all[ch*CNT_W +: CNT_W];

  always_comb begin
    nxt = 8'h00;
    if (op == OP_GET_ADDR) begin
      for (int b = 0; b < ADDR_B; b++)
        if (ptr == PTR_W'(b)) nxt = a_sel[b*8 +: 8];
    end else if (op == OP_GET_CNT) begin
      for (int b = 0; b < CNT_B; b++)
        if (ptr == PTR_W'(b)) nxt = c_sel[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_go) rdata <= nxt;
  end
endmodule

// File: rtl/dma_cmd_prog.sv
module dma_cmd_prog
  import dma_cmd_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IO_W   = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_we,
  input  logic                     exec_we,
  input  logic                     exec_re,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output logic [NUM_CH*IO_W-1:0]   ch_ioport,
  output logic [NUM_CH*ADDR_W-1:0] ch_addr,
  output logic [NUM_CH*CNT_W-1:0]  ch_count,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  output logic [NUM_CH-1:0]        ch_en
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int IO_B   = IO_W / 8;
  localparam int ADDR_B = ADDR_W / 8;
  localparam int CNT_B  = CNT_W / 8;
  localparam int MAX_B  = (ADDR_B > IO_B) ? ((ADDR_B > CNT_B) ? ADDR_B : CNT_B)
                                           : ((IO_B > CNT_B) ? IO_B : CNT_B);
  localparam int PTR_W  = $clog2(MAX_B + 1);

  logic [3:0]       op_q;
  logic [CH_W-1:0]  ch_q;
  logic [PTR_W-1:0] ptr_q;
  logic wr_io, wr_addr, wr_cnt, wr_mode, rd_go, mask_set, mask_clr;

  dma_cmd_seq #(
    .CH_W(CH_W), .PTR_W(PTR_W), .IO_B(IO_B), .ADDR_B(ADDR_B), .CNT_B(CNT_B)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .exec_we(exec_we), .exec_re(exec_re),
    .wdata(wdata), .op_q(op_q), .ch_q(ch_q), .ptr_q(ptr_q),
    .wr_io(wr_io), .wr_addr(wr_addr), .wr_cnt(wr_cnt), .wr_mode(wr_mode),
    .rd_go(rd_go), .mask_set(mask_set), .mask_clr(mask_clr)
  );

  dma_chan_bank #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .PTR_W(PTR_W),
    .IO_W(IO_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_bank (
    .clk(clk), .rst(rst), .sel_ch(ch_q), .mask_ch(wdata[CH_W-1:0]),
    .byte_idx(ptr_q), .wbyte(wdata),
    .wr_io(wr_io), .wr_addr(wr_addr), .wr_cnt(wr_cnt), .wr_mode(wr_mode),
    .mask_set(mask_set), .mask_clr(mask_clr),
    .ch_ioport(ch_ioport), .ch_addr(ch_addr), .ch_count(ch_count),
    .ch_mode(ch_mode), .ch_en(ch_en)
  );

  dma_rd_mux #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_go(rd_go), .op(op_q), .ch(ch_q), .ptr(ptr_q),
    .addr_all(ch_addr), .cnt_all(ch_count), .rdata(rdata)
  );
endmodule

// File: rtl/dma_cmd_prog_chk.sv
module dma_cmd_prog_chk
  import dma_cmd_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IO_W   = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmd_we,
  input logic                     exec_we,
  input logic                     exec_re,
  input logic [7:0]               wdata,
  input logic [7:0]               rdata,
  input logic [NUM_CH*IO_W-1:0]   ch_ioport,
  input logic [NUM_CH*ADDR_W-1:0] ch_addr,
  input logic [NUM_CH*CNT_W-1:0]  ch_count,
  input logic [NUM_CH*MODE_W-1:0] ch_mode,
  input logic [NUM_CH-1:0]        ch_en
);
  localparam int CH_W = $clog2(NUM_CH);

  logic            saw_mask, saw_unmask;
  logic [CH_W-1:0] last_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      saw_mask   <= 1'b0;
      saw_unmask <= 1'b0;
      last_ch    <= '0;
    end else begin
      saw_mask   <= cmd_we && wdata[7:4] == OP_MASK;
      saw_unmask <= cmd_we && wdata[7:4] == OP_UNMASK;
      last_ch    <= wdata[CH_W-1:0];
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ch_en == '0 && rdata == 8'h00 && ch_addr == '0 && ch_mode == '0));

  // R2 R11
  cmd_keeps_regs_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> ($stable(ch_addr) && $stable(ch_count) &&
                $stable(ch_ioport) && $stable(ch_mode)));

  // R2
  idle_keeps_regs_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_we |=> ($stable(ch_addr) && $stable(ch_count) &&
                  $stable(ch_ioport) && $stable(ch_mode)));

  // R7
  mask_drops_en_chk: assert property (@(posedge clk) disable iff (rst)
    saw_mask |-> !ch_en[last_ch]);

  // R7
  unmask_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
    saw_unmask |-> (ch_en[last_ch] == ch_mode[last_ch*MODE_W + MODE_XFER_BIT]));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_re |=> $stable(rdata));
endmodule

bind dma_cmd_prog dma_cmd_prog_chk #(
  .NUM_CH(NUM_CH), .IO_W(IO_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/test_dma_cmd_prog.sv
module test_dma_cmd_prog;
  localparam int NUM_CH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 1'b0, exec_we = 1'b0, exec_re = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [NUM_CH*16-1:0] ch_ioport;
  logic [NUM_CH*24-1:0] ch_addr;
  logic [NUM_CH*16-1:0] ch_count;
  logic [NUM_CH*8-1:0]  ch_mode;
  logic [NUM_CH-1:0]    ch_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_cmd_prog i_dma_cmd_prog (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .exec_we(exec_we), .exec_re(exec_re),
    .wdata(wdata), .rdata(rdata), .ch_ioport(ch_ioport), .ch_addr(ch_addr),
    .ch_count(ch_count), .ch_mode(ch_mode), .ch_en(ch_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk); cmd_we = 1'b1; wdata = b;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic xw(input logic [7:0] b);
    @(negedge clk); exec_we = 1'b1; wdata = b;
    @(negedge clk); exec_we = 1'b0;
  endtask

  task automatic xr(output logic [7:0] b);
    @(negedge clk); exec_re = 1'b1;
    @(negedge clk); exec_re = 1'b0; b = rdata;
  endtask

  function automatic logic [23:0] addr_of(input int c); return ch_addr[c*24 +: 24]; endfunction
  function automatic logic [15:0] cnt_of(input int c);  return ch_count[c*16 +: 16]; endfunction
  function automatic logic [15:0] io_of(input int c);   return ch_ioport[c*16 +: 16]; endfunction
  function automatic logic [7:0]  mode_of(input int c); return ch_mode[c*8 +: 8]; endfunction

  task automatic t_reset;
    check("R1 enables", 32'(ch_en), 32'h0);
    check("R1 rdata", 32'(rdata), 32'h0);
    check("R1 addr ch5", 32'(addr_of(5)), 32'h0);
    check("R1 mode ch5", 32'(mode_of(5)), 32'h0);
    xw(8'h77);
    check("R1 early exec byte", 32'(ch_addr[31:0] | ch_mode[31:0] | ch_ioport[31:0]), 32'h0);
  endtask

  task automatic t_program;
    cmd(8'h95);
    cmd(8'h75); xw(8'h4C);
    check("R6 mode ch5", 32'(mode_of(5)), 32'h4C);
    check("R7 masked no enable", 32'(ch_en[5]), 32'h0);
    cmd(8'h25); xw(8'h56); xw(8'h34); xw(8'h12);
    check("R3 address ch5", 32'(addr_of(5)), 32'h123456);
    cmd(8'h45); xw(8'hFF); xw(8'h7F);
    check("R4 count ch5", 32'(cnt_of(5)), 32'h7FFF);
    cmd(8'hA5);
    check("R7 unmask enables", 32'(ch_en), 32'h0020);
    check("R12 ch4 addr untouched", 32'(addr_of(4)), 32'h0);
    check("R12 ch6 mode untouched", 32'(mode_of(6)), 32'h0);
  endtask

  task automatic t_ioport;
    cmd(8'h00); xw(8'hEF); xw(8'hBE);
    check("R5 ioport ch0", 32'(io_of(0)), 32'hBEEF);
    check("R12 ch5 ioport untouched", 32'(io_of(5)), 32'h0);
  endtask

  task automatic t_extra;
    cmd(8'h2A); xw(8'h01); xw(8'h02); xw(8'h03); xw(8'h04);
    check("R8 surplus byte ignored", 32'(addr_of(10)), 32'h030201);
    cmd(8'h2A); xw(8'h11);
    check("R8 pointer restart", 32'(addr_of(10)), 32'h030211);
  endtask

  task automatic t_unlisted;
    cmd(8'hB3); xw(8'h55);
    cmd(8'h13); xw(8'h66);
    cmd(8'h63); xw(8'h77);
    check("R9 ch3 addr", 32'(addr_of(3)), 32'h0);
    check("R9 ch3 mode/count/io", 32'({mode_of(3), cnt_of(3)} | 32'(io_of(3))), 32'h0);
    check("R9 enables unchanged", 32'(ch_en), 32'h0020);
  endtask

  task automatic t_readback;
    logic [7:0] b;
    cmd(8'h35);
    xr(b); check("R10 addr byte0", 32'(b), 32'h56);
    xr(b); check("R10 addr byte1", 32'(b), 32'h34);
    xr(b); check("R10 addr byte2", 32'(b), 32'h12);
    xr(b); check("R10 read past end", 32'(b), 32'h00);
    cmd(8'h55);
    xr(b); check("R10 count byte0", 32'(b), 32'hFF);
    xr(b); check("R10 count byte1", 32'(b), 32'h7F);
    cmd(8'h65);
    xr(b); check("R10 status stub", 32'(b), 32'h00);
  endtask

  task automatic t_enable_terms;
    cmd(8'h97); cmd(8'h77); xw(8'h08); cmd(8'hA7);
    check("R7 no transfer bit", 32'(ch_en[7]), 32'h0);
    cmd(8'h95);
    check("R7 mask clears enable", 32'(ch_en[5]), 32'h0);
    check("R2 mask keeps mode", 32'(mode_of(5)), 32'h4C);
  endtask

  task automatic t_collide;
    cmd(8'h2C); xw(8'hAA);
    @(negedge clk); cmd_we = 1'b1; exec_we = 1'b1; wdata = 8'h2C;
    @(negedge clk); cmd_we = 1'b0; exec_we = 1'b0;
    check("R11 exec ignored", 32'(addr_of(12)), 32'h0000AA);
    xw(8'h77);
    check("R11 command restarted", 32'(addr_of(12)), 32'h000077);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_ioport();
    t_extra();
    t_unlisted();
    t_readback();
    t_enable_terms();
    t_collide();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule